// File: doc/BRIEF.md
# Transmit Descriptor List Walker

This block follows a list of transmit descriptors kept in host memory. Each descriptor is four 32-bit words (16 bytes). The walker reads all four words of a descriptor over a simple read port. It then checks that the engine owns the descriptor and passes up to two buffer requests (address and byte count) to a downstream data mover. Last, it works out where the next descriptor lives.

The next address is chosen per descriptor. A descriptor can be laid out in ring fashion, where the next one follows at +16 and an end-of-ring mark sends the walker back to the list base. It can also be chained, where the last word is a link to the next descriptor. The end-of-ring mark takes precedence over chaining.

Software loads a base address, then writes the run bit in a control word. Clearing the run bit lets the current descriptor finish before the walker stops. A descriptor the engine does not own parks the walker until a poll pulse asks it to look again.

Top module: `txdesc_walker`

## Requirements
- R1: After reset the walker is stopped (`walk_stopped`=1). It has `chain_err`=0, and it drives no memory read and no buffer request.
- R2: The walker leaves the stopped state only on a control write with bit 13 set, and only if a base address has been loaded before that write. The first descriptor is then read at the loaded base.
- R3: A descriptor is read as four word reads, at offsets +0, +4, +8 and +12, one at a time. Each read uses a valid/ready request followed by a response, and each word is read once per opening. A held request keeps its address.
- R4: Buffer requests start only after all four words have arrived. The first request carries word 2 unmodified as its address and word 1 bits 10:0 as its length, with `buf_second`=0. The second carries word 3 and word 1 bits 21:11, with `buf_second`=1. The first precedes the second, and a request is held stable until `buf_ready`.
- R5: A buffer whose length field is zero is skipped and produces no request.
- R6: With word 1 bits 24 and 25 both clear, the next descriptor is at the current address plus 16.
- R7: With word 1 bit 24 set and bit 25 clear (chained), the next descriptor address is word 3, and no second-buffer request is made.
- R8: With word 1 bit 25 set (end of ring), bit 24 is ignored. Word 3 is a second-buffer pointer, and the next descriptor is read at the base address.
- R9: In chained mode, a link whose low 4 bits are not zero sets `chain_err` and stops the walker with no further reads. The next accepted start clears `chain_err`.
- R10: When word 0 bit 31 is clear, the walker issues no buffer request and enters the suspended state (`walk_suspended`=1). A `poll_demand` pulse re-reads the same descriptor.
- R11: A control write with bit 13 clear lets the current descriptor finish, including its buffer requests, and then stops the walker without reading another descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word; bit 13 is the run bit |
| base_wr | input | 1 | Base address write strobe |
| base_wdata | input | 32 | Descriptor list base address |
| poll_demand | input | 1 | Pulse: re-examine a descriptor that was not owned |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| buf_valid | output | 1 | Buffer request valid |
| buf_ready | input | 1 | Data mover accepts the buffer request |
| buf_addr | output | 32 | Buffer start address |
| buf_len | output | 11 | Buffer byte count |
| buf_second | output | 1 | 0 = first buffer, 1 = second buffer |
| walk_stopped | output | 1 | Walker is stopped |
| walk_suspended | output | 1 | Walker waits for a poll after an unowned descriptor |
| chain_err | output | 1 | A misaligned chained link was found |

## Verification
The bench builds the walker with its defaults: four words per descriptor, 32-bit addresses and 11-bit length fields. This keeps the list small enough to sit in a 1 KB bench memory, where ring wrap, chained links to distant addresses and an end-of-ring jump back to base are all in range. A stall mode on the memory ready line and a held-low sink ready line exercise the read handshake, request hold and the stop-after-finish path with byte-unaligned buffer pointers.

// File: rtl/txw_pkg.sv
package txw_pkg;

  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 32;
  localparam int LEN_W      = 11;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * (WORD_W / 8);

  localparam int OWN_BIT    = 31;
  localparam int CHAIN_BIT  = 24;
  localparam int EOR_BIT    = 25;
  localparam int LEN1_LO    = 0;
  localparam int LEN2_LO    = 11;
  localparam int RUN_BIT    = 13;

  typedef enum logic [2:0] {
    ST_STOP,
    ST_LOAD,
    ST_WAIT,
    ST_BUF1,
    ST_BUF2,
    ST_NEXT,
    ST_SUSP
  } walk_st_t;

  // Second-buffer pointer is in use unless the descriptor is chained.
  function automatic logic second_is_buffer(input logic [WORD_W-1:0] w1);
    return w1[EOR_BIT] || !w1[CHAIN_BIT];
  endfunction

  // Address of the descriptor after the current one.
  function automatic logic [ADDR_W-1:0] next_desc_addr(
    input logic [ADDR_W-1:0] cur,
    input logic [ADDR_W-1:0] base,
    input logic [WORD_W-1:0] w1,
    input logic [WORD_W-1:0] w3
  );
    if (w1[EOR_BIT])        return base;
    else if (w1[CHAIN_BIT]) return w3;
    else                    return cur + ADDR_W'(DESC_BYTES);
  endfunction

  // Chained link that is not on a descriptor boundary.
  function automatic logic link_misaligned(
    input logic [WORD_W-1:0] w1,
    input logic [WORD_W-1:0] w3
  );
    return !w1[EOR_BIT] && w1[CHAIN_BIT] && (w3[3:0] != 4'd0);
  endfunction

  function automatic logic [LEN_W-1:0] len_field(input logic [WORD_W-1:0] w1,
                                                 input logic second);
    return second ? w1[LEN2_LO +: LEN_W] : w1[LEN1_LO +: LEN_W];
  endfunction

endpackage

// File: rtl/txw_fetch.sv
module txw_fetch
  import txw_pkg::*;
#(
  parameter int NWORDS = DESC_WORDS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go,
  input  logic [ADDR_W-1:0]             desc_addr,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [ADDR_W-1:0]             mem_req_addr,
  input  logic                          mem_rsp_valid,
  input  logic [WORD_W-1:0]             mem_rsp_data,
  output logic [NWORDS-1:0][WORD_W-1:0] words,
  output logic                          busy,
  output logic                          done
);

  localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int BYTE_SHIFT = $clog2(WORD_W / 8);

  logic              active;
  logic              pending;
  logic [IW-1:0]     idx;
  logic [ADDR_W-1:0] base_q;

  // named events for the checks below
  logic req_fire;
  logic rsp_take;
  logic last_word;

  assign req_fire  = mem_req_valid && mem_req_ready;
  assign rsp_take  = active && pending && mem_rsp_valid;
  assign last_word = (idx == IW'(NWORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pending <= 1'b0;
      idx     <= '0;
      base_q  <= '0;
      words   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active  <= 1'b1;
        pending <= 1'b0;
        idx     <= '0;
        base_q  <= desc_addr;
      end else if (active) begin
        if (req_fire) pending <= 1'b1;
        if (rsp_take) begin
          words[idx] <= mem_rsp_data;
          pending    <= 1'b0;
          if (last_word) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  assign mem_req_valid = active && !pending;
  assign mem_req_addr  = base_q + (ADDR_W'(idx) << BYTE_SHIFT);
  assign busy          = active;

  // R3: a waiting request keeps its address
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R3: descriptor words are captured once and not touched between openings
  assert_words_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !go) |=> $stable(words));

  // R3: completion follows the final word's response
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(rsp_take) && !active));

endmodule

// File: rtl/txw_select.sv
module txw_select
  import txw_pkg::*;
(
  input  logic              second,
  input  logic [WORD_W-1:0] w1,
  input  logic [WORD_W-1:0] w2,
  input  logic [WORD_W-1:0] w3,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [LEN_W-1:0]  sel_len,
  output logic              sel_use
);

  logic [LEN_W-1:0] len_now;

  always_comb begin
    len_now  = len_field(w1, second);
    sel_len  = len_now;
    sel_addr = second ? w3 : w2;
    if (second) sel_use = second_is_buffer(w1) && (len_now != '0);
    else        sel_use = (len_now != '0);
  end

endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
  import txw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [31:0]       ctrl_wdata,
  input  logic              base_wr,
  input  logic [31:0]       base_wdata,
  input  logic              poll_demand,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              buf_valid,
  input  logic              buf_ready,
  output logic [31:0]       buf_addr,
  output logic [10:0]       buf_len,
  output logic              buf_second,
  output logic              walk_stopped,
  output logic              walk_suspended,
  output logic              chain_err
);

  walk_st_t          st;
  logic [ADDR_W-1:0] base_q;
  logic              base_ok;
  logic              run_en;
  logic [ADDR_W-1:0] cur;
  logic              err_q;

  logic [DESC_WORDS-1:0][WORD_W-1:0] dw;
  logic fetch_busy;
  logic fetch_done;

  // named events
  logic start_wr;
  logic launch;
  logic desc_owned;
  logic sel_use;
  logic buf_fire;
  logic bad_link;
  logic [ADDR_W-1:0] nxt_addr;
  logic unused_bits;

  assign start_wr   = ctrl_wr && ctrl_wdata[RUN_BIT];
  assign launch     = (st == ST_STOP) && start_wr && base_ok;
  assign desc_owned = dw[0][OWN_BIT];
  assign buf_fire   = buf_valid && buf_ready;
  assign bad_link   = link_misaligned(dw[1], dw[3]);
  assign nxt_addr   = next_desc_addr(cur, base_q, dw[1], dw[3]);
  assign unused_bits = ^{ctrl_wdata[31:RUN_BIT+1], ctrl_wdata[RUN_BIT-1:0],
                         dw[0][OWN_BIT-1:0], fetch_busy};

  txw_fetch #(.NWORDS(DESC_WORDS)) u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .go            (st == ST_LOAD),
    .desc_addr     (cur),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .words         (dw),
    .busy          (fetch_busy),
    .done          (fetch_done)
  );

  txw_select u_select (
    .second   (st == ST_BUF2),
    .w1       (dw[1]),
    .w2       (dw[2]),
    .w3       (dw[3]),
    .sel_addr (buf_addr),
    .sel_len  (buf_len),
    .sel_use  (sel_use)
  );

  assign buf_valid      = ((st == ST_BUF1) || (st == ST_BUF2)) && sel_use;
  assign buf_second     = (st == ST_BUF2);
  assign walk_stopped   = (st == ST_STOP);
  assign walk_suspended = (st == ST_SUSP);
  assign chain_err      = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_STOP;
      base_q  <= '0;
      base_ok <= 1'b0;
      run_en  <= 1'b0;
      cur     <= '0;
      err_q   <= 1'b0;
    end else begin
      if (base_wr) begin
        base_q  <= base_wdata;
        base_ok <= 1'b1;
      end
      if (ctrl_wr) run_en <= ctrl_wdata[RUN_BIT];
      unique case (st)
        ST_STOP: if (launch) begin
          cur   <= base_q;
          err_q <= 1'b0;
          st    <= ST_LOAD;
        end
        ST_LOAD: st <= ST_WAIT;
        ST_WAIT: if (fetch_done) st <= desc_owned ? ST_BUF1 : ST_SUSP;
        ST_BUF1: if (!sel_use || buf_ready) st <= ST_BUF2;
        ST_BUF2: if (!sel_use || buf_ready) st <= ST_NEXT;
        ST_NEXT: begin
          if (bad_link) begin
            err_q <= 1'b1;
            st    <= ST_STOP;
          end else begin
            cur <= nxt_addr;
            st  <= run_en ? ST_LOAD : ST_STOP;
          end
        end
        ST_SUSP: begin
          if (!run_en)          st <= ST_STOP;
          else if (poll_demand) st <= ST_LOAD;
        end
        default: st <= ST_STOP;
      endcase
    end
  end

  // R1: nothing leaves a stopped walker
  assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    walk_stopped |-> (!mem_req_valid && !buf_valid));

  // R2: a start reads from the loaded base
  assert_launch_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (st == ST_LOAD && cur == $past(base_q)));

  // R4: a stalled buffer request is held
  assert_buf_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !buf_ready) |=>
      (buf_valid && $stable(buf_addr) && $stable(buf_len) && $stable(buf_second)));

  // R4: no buffer request while a descriptor is still being read
  assert_buf_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> !mem_req_valid);

  // R5: zero-length buffers never reach the data mover
  assert_buf_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (buf_len != '0));

  // R7: a chained descriptor has no second buffer
  assert_chain_no_b2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && buf_second) |-> (dw[1][EOR_BIT] || !dw[1][CHAIN_BIT]));

  // R9: the error flag only rises as the walker stops
  assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chain_err) |-> walk_stopped);

  // R10: a suspended walker issues nothing
  assert_susp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_suspended |-> (!buf_valid && !mem_req_valid));

endmodule

// File: tb/txdesc_walker_bench.sv
module txdesc_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        poll_demand = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        buf_valid;
  logic        buf_ready;
  logic [31:0] buf_addr;
  logic [10:0] buf_len;
  logic        buf_second;
  logic        walk_stopped;
  logic        walk_suspended;
  logic        chain_err;

  always #10 clk = ~clk;

  txdesc_walker u_txdesc_walker (.*);

  logic [31:0] mem [0:255];
  logic        mem_stall = 1'b0;
  logic        sink_rdy = 1'b1;
  logic        log_clr = 1'b0;
  logic [7:0]  cnt = '0;
  logic [31:0] rd_a [0:63];
  int          rd_n = 0;
  logic [31:0] bx_a [0:15];
  logic [10:0] bx_l [0:15];
  logic        bx_s [0:15];
  int          bx_n = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  assign mem_req_ready = !mem_stall || cnt[0];
  assign buf_ready     = sink_rdy;

  always @(posedge clk) begin
    cnt           <= cnt + 8'd1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[9:2]];
    end
    if (log_clr) begin
      rd_n <= 0;
      bx_n <= 0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        if (rd_n < 64) rd_a[rd_n] <= mem_req_addr;
        rd_n <= rd_n + 1;
      end
      if (buf_valid && buf_ready) begin
        if (bx_n < 16) begin
          bx_a[bx_n] <= buf_addr;
          bx_l[bx_n] <= buf_len;
          bx_s[bx_n] <= buf_second;
        end
        bx_n <= bx_n + 1;
      end
    end
  end

  function automatic logic [31:0] w1_of(input int l1, input int l2,
                                        input bit ch, input bit eor);
    return 32'(l1) | (32'(l2) << 11) | (32'(ch) << 24) | (32'(eor) << 25);
  endfunction

  // next descriptor per R6/R7/R8, written independently
  function automatic logic [31:0] exp_next(input logic [31:0] cur, base, w1, w3);
    case ({w1[25], w1[24]})
      2'b00:   return cur + 32'h10;
      2'b01:   return w3;
      default: return base;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, w0, w1, w2, w3);
    mem[a[9:2]]     = w0;
    mem[a[9:2] + 1] = w1;
    mem[a[9:2] + 2] = w2;
    mem[a[9:2] + 3] = w3;
  endtask

  task automatic wr_ctrl(input bit run);
    @(negedge clk);
    ctrl_wr = 1'b1;
    ctrl_wdata = run ? 32'h0000_2000 : 32'h0;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_base(input logic [31:0] a);
    @(negedge clk);
    base_wr = 1'b1;
    base_wdata = a;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
  endtask

  task automatic chk_desc_reads(input string req, input int first, input logic [31:0] da);
    for (int k = 0; k < 4; k++)
      chk(req, rd_a[first + k], da + 32'(4 * k));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 stopped", 32'(walk_stopped), 32'd1);
    chk("R1 err", 32'(chain_err), 32'd0);
    chk("R1 no read", 32'(mem_req_valid), 32'd0);
    chk("R1 no buf", 32'(buf_valid), 32'd0);
  endtask

  task automatic t_start_gate();
    clear_log();
    wr_ctrl(1'b1);
    repeat (20) @(negedge clk);
    chk("R2 no base no read", 32'(rd_n), 32'd0);
    chk("R2 still stopped", 32'(walk_stopped), 32'd1);
    wr_base(32'h100);
    repeat (20) @(negedge clk);
    chk("R2 base alone no read", 32'(rd_n), 32'd0);
  endtask

  task automatic t_ring();
    logic [31:0] w1a, w1b, n1, n2;
    w1a = w1_of(8, 5, 1'b0, 1'b0);
    w1b = w1_of(3, 7, 1'b1, 1'b1);
    put_desc(32'h100, 32'h8000_0000, w1a, 32'h1003, 32'h2001);
    put_desc(32'h110, 32'h8000_0000, w1b, 32'h3000, 32'h4002);
    n1 = exp_next(32'h100, 32'h100, w1a, 32'h2001);
    n2 = exp_next(n1, 32'h100, w1b, 32'h4002);
    mem_stall = 1'b1;
    clear_log();
    wr_ctrl(1'b1);
    for (int i = 0; i < 300 && bx_n < 1; i++) @(negedge clk);
    mem[32'h100 >> 2] = 32'h0;
    repeat (200) @(negedge clk);
    mem_stall = 1'b0;
    chk("R3 ring read count", 32'(rd_n), 32'd12);
    chk_desc_reads("R2 R3 first at base", 0, 32'h100);
    chk_desc_reads("R6 ring +16", 4, n1);
    chk_desc_reads("R8 wrap to base", 8, n2);
    chk("R4 count", 32'(bx_n), 32'd4);
    chk("R4 b1 addr", bx_a[0], 32'h1003);
    chk("R4 b1 len", 32'(bx_l[0]), 32'd8);
    chk("R4 b1 sel", 32'(bx_s[0]), 32'd0);
    chk("R4 b2 addr", bx_a[1], 32'h2001);
    chk("R4 b2 len", 32'(bx_l[1]), 32'd5);
    chk("R4 b2 sel", 32'(bx_s[1]), 32'd1);
    chk("R8 eor b1 addr", bx_a[2], 32'h3000);
    chk("R8 eor b2 addr", bx_a[3], 32'h4002);
    chk("R8 eor b2 len", 32'(bx_l[3]), 32'd7);
    chk("R9 eor no err", 32'(chain_err), 32'd0);
    chk("R10 suspended", 32'(walk_suspended), 32'd1);
  endtask

  task automatic t_poll();
    clear_log();
    @(negedge clk);
    poll_demand = 1'b1;
    @(negedge clk);
    poll_demand = 1'b0;
    repeat (60) @(negedge clk);
    chk("R10 poll reread count", 32'(rd_n), 32'd4);
    chk_desc_reads("R10 poll same desc", 0, 32'h100);
    chk("R10 no buffers", 32'(bx_n), 32'd0);
    chk("R10 still suspended", 32'(walk_suspended), 32'd1);
    wr_ctrl(1'b0);
    repeat (5) @(negedge clk);
    chk("R11 stop from suspend", 32'(walk_stopped), 32'd1);
  endtask

  task automatic t_chain();
    put_desc(32'h200, 32'h8000_0000, w1_of(4, 9, 1'b1, 1'b0), 32'h5000, 32'h340);
    put_desc(32'h340, 32'h8000_0000, w1_of(0, 6, 1'b1, 1'b0), 32'h9999, 32'h384);
    wr_base(32'h200);
    clear_log();
    wr_ctrl(1'b1);
    repeat (200) @(negedge clk);
    chk("R7 R9 read count", 32'(rd_n), 32'd8);
    chk_desc_reads("R7 chained link", 4, 32'h340);
    chk("R7 one buffer", 32'(bx_n), 32'd1);
    chk("R7 b1 addr", bx_a[0], 32'h5000);
    chk("R5 R7 b1 len", 32'(bx_l[0]), 32'd4);
    chk("R9 err set", 32'(chain_err), 32'd1);
    chk("R9 stopped", 32'(walk_stopped), 32'd1);
  endtask

  task automatic t_zero();
    put_desc(32'h080, 32'h8000_0000, w1_of(0, 2, 1'b0, 1'b0), 32'hAAAA, 32'h6006);
    put_desc(32'h090, 32'h0, w1_of(1, 1, 1'b0, 1'b0), 32'hBBBB, 32'hCCCC);
    wr_base(32'h080);
    clear_log();
    wr_ctrl(1'b1);
    repeat (3) @(negedge clk);
    chk("R9 err cleared by start", 32'(chain_err), 32'd0);
    repeat (150) @(negedge clk);
    chk("R5 one buffer", 32'(bx_n), 32'd1);
    chk("R5 b2 addr", bx_a[0], 32'h6006);
    chk("R5 b2 len", 32'(bx_l[0]), 32'd2);
    chk("R5 b2 sel", 32'(bx_s[0]), 32'd1);
    chk("R6 reads", 32'(rd_n), 32'd8);
    chk_desc_reads("R6 next +16", 4, 32'h090);
    chk("R10 unowned suspends", 32'(walk_suspended), 32'd1);
    wr_ctrl(1'b0);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_stop_finish();
    put_desc(32'h000, 32'h8000_0000, w1_of(1, 0, 1'b0, 1'b0), 32'h7000, 32'h0);
    put_desc(32'h010, 32'h8000_0000, w1_of(1, 0, 1'b0, 1'b0), 32'h7100, 32'h0);
    sink_rdy = 1'b0;
    wr_base(32'h000);
    clear_log();
    wr_ctrl(1'b1);
    for (int i = 0; i < 100 && !buf_valid; i++) @(negedge clk);
    wr_ctrl(1'b0);
    repeat (10) @(negedge clk);
    chk("R4 held valid", 32'(buf_valid), 32'd1);
    chk("R4 held addr", buf_addr, 32'h7000);
    chk("R11 not yet stopped", 32'(walk_stopped), 32'd0);
    sink_rdy = 1'b1;
    repeat (30) @(negedge clk);
    chk("R11 buffer finished", 32'(bx_n), 32'd1);
    chk("R11 stopped", 32'(walk_stopped), 32'd1);
    chk("R11 no next read", 32'(rd_n), 32'd4);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_gate();
    t_ring();
    t_poll();
    t_chain();
    t_zero();
    t_stop_finish();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule